// File: doc/BRIEF.md
# Timer Status Flag Register

This block keeps the four event flags of a 16-bit timer (input capture, compare channel A, compare channel B and overflow) and presents them as one 8-bit read value. A flag sets when the hardware event that belongs to it occurs. The counter, the waveform generator, the capture latch and the interrupt controller all sit outside this block.

Software clears a flag by writing a one to its bit position. The interrupt controller clears a flag by sending a one-cycle acknowledge pulse for that flag. Every set condition is evaluated only on cycles where the timer clock enable is high. Clears act on any system clock cycle.

All pins are plain control and status signals. There is no streaming interface, so no valid/ready handshake and no back-pressure.

The `wave_mode` selector takes four values:
- 0: normal counting.
- 1: clear-on-match counting.
- 2: the capture register holds TOP.
- 3: some other register holds TOP.

Top module: `tmr_flag_reg`

## Requirements
- R1: Read bits 7, 6, 4 and 3 are always zero. A bus write whose one-bits fall only in those positions changes no flag.
- R2: The read value carries the capture flag at bit 5, compare B at bit 2, compare A at bit 1 and overflow at bit 0. After reset every bit is 0.
- R3: When `tmr_count` equals a channel's compare value on a cycle with `tmr_tick` high, that channel's flag sets on the next `tmr_tick` cycle, not in the matching one.
- R4: `force_a` and `force_b` never set a compare flag.
- R5: In modes 0, 1 and 3, `cap_event` high on a tick cycle sets the capture flag.
- R6: In mode 2, the capture flag sets on a tick cycle where `tmr_count` equals `top_val`, and `cap_event` has no effect.
- R7: In modes 0 and 1, `cnt_wrap` high on a tick cycle sets the overflow flag.
- R8: In modes 2 and 3, the overflow flag sets on a tick cycle where `tmr_count` equals `top_val`, and `cnt_wrap` has no effect.
- R9: A bus write clears each flag whose bit (positions as in R2) is one, and leaves flags written with zero unchanged.
- R10: `irq_ack[0]`, `[1]`, `[2]` and `[3]` each clear one flag: overflow, compare A, compare B and capture respectively.
- R11: When a set condition and a clear meet on the same cycle, the flag ends up set.
- R12: No flag sets on a cycle with `tmr_tick` low. Clears still act on such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_tick | input | 1 | Timer clock enable |
| tmr_count | input | 16 | Counter value |
| cmp_a_val | input | 16 | Compare value, channel A |
| cmp_b_val | input | 16 | Compare value, channel B |
| top_val | input | 16 | TOP value |
| cap_event | input | 1 | Capture event pulse |
| force_a | input | 1 | Force-compare strobe, channel A |
| force_b | input | 1 | Force-compare strobe, channel B |
| wave_mode | input | 2 | Counting mode (see the list above) |
| cnt_wrap | input | 1 | Counter wrapped past its maximum |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| irq_ack | input | 4 | Per-flag interrupt acknowledge pulses |
| reg_rdata | output | 8 | Register read value |
| flag_ovf | output | 1 | Overflow flag |
| flag_cmp_a | output | 1 | Compare A flag |
| flag_cmp_b | output | 1 | Compare B flag |
| flag_cap | output | 1 | Capture flag |

## Verification
The only hidden state is one pending-match bit per compare channel, alongside the four flags themselves. A stale or missing pending bit shows up as a compare flag that sets one tick too early, too late or not at all. That error is visible at the ports on the next tick cycle. A flag with a wrong value shows up on `reg_rdata` and on the flag pins in the very next cycle, so comparing every cycle against a reference model catches either fault within a tick of its cause.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL    = 2'd0,
    MODE_CLR_MATCH = 2'd1,
    MODE_TOP_CAP   = 2'd2,
    MODE_TOP_OTHER = 2'd3
  } wave_mode_e;

  // flag indices inside the internal vectors (also the ack order)
  localparam int IDX_OVF  = 0;
  localparam int IDX_CMPA = 1;
  localparam int IDX_CMPB = 2;
  localparam int IDX_CAP  = 3;
  localparam int NFLAG    = 4;

  // bit positions in the read/write register
  localparam int BIT_OVF  = 0;
  localparam int BIT_CMPA = 1;
  localparam int BIT_CMPB = 2;
  localparam int BIT_CAP  = 5;
  localparam int REG_W    = 8;
endpackage

// File: rtl/tfr_match_stage.sv
// Records a compare hit on a tick so the flag can set on the following tick.
module tfr_match_stage #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cmp,
  output logic          pend
);
  always_ff @(posedge clk) begin
    if (!rst_n)    pend <= 1'b0;
    else if (tick) pend <= (count == cmp);
  end
endmodule

// File: rtl/tfr_flag_cell.sv
// One sticky flag; a set request outranks a clear request.
module tfr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/tmr_flag_reg.sv
module tmr_flag_reg
  import tfr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_tick,
  input  logic [CW-1:0] tmr_count,
  input  logic [CW-1:0] cmp_a_val,
  input  logic [CW-1:0] cmp_b_val,
  input  logic [CW-1:0] top_val,
  input  logic          cap_event,
  input  logic          force_a,
  input  logic          force_b,
  input  logic [1:0]    wave_mode,
  input  logic          cnt_wrap,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  input  logic [3:0]    irq_ack,
  output logic [7:0]    reg_rdata,
  output logic          flag_ovf,
  output logic          flag_cmp_a,
  output logic          flag_cmp_b,
  output logic          flag_cap
);
  localparam int NCH = 2;

  wave_mode_e          mode;
  logic [CW-1:0]       cmp_v [NCH];
  logic [NCH-1:0]      pend;
  logic                top_hit;
  logic [NFLAG-1:0]    set_v, wr_clr, clr_v, flag_v;

  assign mode     = wave_mode_e'(wave_mode);
  assign cmp_v[0] = cmp_a_val;
  assign cmp_v[1] = cmp_b_val;
  assign top_hit  = (tmr_count == top_val);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tfr_match_stage #(.CW(CW)) u_match (
      .clk(clk), .rst_n(rst_n), .tick(tmr_tick),
      .count(tmr_count), .cmp(cmp_v[c]), .pend(pend[c])
    );
  end

  always_comb begin
    set_v = '0;
    if (tmr_tick) begin
      set_v[IDX_OVF]  = (mode == MODE_NORMAL || mode == MODE_CLR_MATCH) ? cnt_wrap : top_hit;
      set_v[IDX_CMPA] = pend[0];
      set_v[IDX_CMPB] = pend[1];
      set_v[IDX_CAP]  = (mode == MODE_TOP_CAP) ? top_hit : cap_event;
    end
  end

  always_comb begin
    wr_clr = '0;
    if (bus_wr) begin
      wr_clr[IDX_OVF]  = bus_wdata[BIT_OVF];
      wr_clr[IDX_CMPA] = bus_wdata[BIT_CMPA];
      wr_clr[IDX_CMPB] = bus_wdata[BIT_CMPB];
      wr_clr[IDX_CAP]  = bus_wdata[BIT_CAP];
    end
  end
  assign clr_v = wr_clr | irq_ack;

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    tfr_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[f]), .clr_i(clr_v[f]), .q(flag_v[f])
    );
  end

  assign flag_ovf   = flag_v[IDX_OVF];
  assign flag_cmp_a = flag_v[IDX_CMPA];
  assign flag_cmp_b = flag_v[IDX_CMPB];
  assign flag_cap   = flag_v[IDX_CAP];

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[BIT_OVF]  = flag_v[IDX_OVF];
    reg_rdata[BIT_CMPA] = flag_v[IDX_CMPA];
    reg_rdata[BIT_CMPB] = flag_v[IDX_CMPB];
    reg_rdata[BIT_CAP]  = flag_v[IDX_CAP];
  end

  // ---------------- assertions ----------------
  p_reserved_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_wdata & 8'h27) == 8'h00 && set_v == '0 && irq_ack == '0)
      |=> reg_rdata == $past(reg_rdata));

  p_cmp_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_tick && pend[0]) |=> flag_cmp_a);

  p_force_inert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((force_a || force_b) && !(tmr_tick && pend[0]) && !flag_cmp_a) |=> !flag_cmp_a);

  p_wr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[BIT_OVF] && !set_v[IDX_OVF]) |=> !flag_ovf);

  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack[IDX_CMPB] && !(tmr_tick && pend[1])) |=> !flag_cmp_b);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v[IDX_CAP] && clr_v[IDX_CAP]) |=> flag_cap);

  p_no_idle_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_tick && !flag_ovf) |=> !flag_ovf);

  p_top_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_tick && mode == MODE_TOP_CAP && top_hit) |=> flag_cap);
endmodule

// File: tb/sim_tmr_flag_reg.sv
module sim_tmr_flag_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_tick = 1'b0;
  logic [15:0] tmr_count = '0, cmp_a_val = '0, cmp_b_val = '0, top_val = '0;
  logic        cap_event = 1'b0, force_a = 1'b0, force_b = 1'b0, cnt_wrap = 1'b0;
  logic [1:0]  wave_mode = 2'd0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [3:0]  irq_ack = '0;
  logic [7:0]  reg_rdata;
  logic        flag_ovf, flag_cmp_a, flag_cmp_b, flag_cap;

  always #5 clk = ~clk;

  tmr_flag_reg u0 (
    .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .tmr_count(tmr_count),
    .cmp_a_val(cmp_a_val), .cmp_b_val(cmp_b_val), .top_val(top_val),
    .cap_event(cap_event), .force_a(force_a), .force_b(force_b),
    .wave_mode(wave_mode), .cnt_wrap(cnt_wrap), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .irq_ack(irq_ack), .reg_rdata(reg_rdata),
    .flag_ovf(flag_ovf), .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b),
    .flag_cap(flag_cap)
  );

  // behavioural reference: flags m_o, m_a, m_b, m_c; pending hits pa, pb
  bit m_o, m_a, m_b, m_c, pa, pb;
  always @(posedge clk) begin
    bit so, sa, sb, sc, co, ca, cb, cc;
    if (!rst_n) begin
      m_o <= 0; m_a <= 0; m_b <= 0; m_c <= 0; pa <= 0; pb <= 0;
    end else begin
      so = tmr_tick && ((wave_mode < 2) ? cnt_wrap : (tmr_count == top_val));
      sc = tmr_tick && ((wave_mode == 2) ? (tmr_count == top_val) : cap_event);
      sa = tmr_tick && pa;
      sb = tmr_tick && pb;
      co = irq_ack[0] || (bus_wr && bus_wdata[0]);
      ca = irq_ack[1] || (bus_wr && bus_wdata[1]);
      cb = irq_ack[2] || (bus_wr && bus_wdata[2]);
      cc = irq_ack[3] || (bus_wr && bus_wdata[5]);
      m_o <= so ? 1'b1 : (co ? 1'b0 : m_o);
      m_a <= sa ? 1'b1 : (ca ? 1'b0 : m_a);
      m_b <= sb ? 1'b1 : (cb ? 1'b0 : m_b);
      m_c <= sc ? 1'b1 : (cc ? 1'b0 : m_c);
      if (tmr_tick) begin
        pa <= (tmr_count == cmp_a_val);
        pb <= (tmr_count == cmp_b_val);
      end
    end
  end

  int    n_cmp = 0, n_bad = 0;
  string tag = "R2";
  bit    done = 0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1", int'({reg_rdata[7:6], reg_rdata[4:3]}), 0);
    chk("R2", int'(reg_rdata), int'({2'b00, m_c, 2'b00, m_b, m_a, m_o}));
    chk(tag, int'({flag_cap, flag_cmp_b, flag_cmp_a, flag_ovf}), int'({m_c, m_b, m_a, m_o}));
  endtask

  // one phase: per-cycle random stimulus shaped by knobs, compared each cycle
  task automatic run(string t, int cycles, int tick_pct, int mode_lo, int mode_hi,
                     int wr_pct, int ack_pct, int ev_pct, bit force_only);
    tag = t;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_all();
      tmr_tick  = ($urandom_range(99) < tick_pct);
      wave_mode = 2'($urandom_range(mode_hi, mode_lo));
      tmr_count = 16'($urandom_range(7));
      top_val   = 16'($urandom_range(7));
      cmp_a_val = force_only ? 16'hFFFF : 16'($urandom_range(7));
      cmp_b_val = force_only ? 16'hFFF0 : 16'($urandom_range(7));
      cap_event = ($urandom_range(99) < ev_pct);
      cnt_wrap  = ($urandom_range(99) < ev_pct);
      force_a   = $urandom_range(1) == 1;
      force_b   = $urandom_range(1) == 1;
      bus_wr    = ($urandom_range(99) < wr_pct);
      bus_wdata = (t == "R1") ? (8'($urandom) & 8'hD8) : 8'($urandom);
      irq_ack   = ($urandom_range(99) < ack_pct) ? 4'($urandom) : 4'h0;
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      compare_all();                       // reset state (R2)
      chk("R2", int'(reg_rdata), 0);
    end
    rst_n = 1'b1;
    run("R3",  400, 70, 0, 0,  0,  0, 0, 0);
    run("R9",  300, 60, 0, 1, 30,  0, 30, 0);
    run("R4",  200, 80, 0, 1,  0,  0, 0, 1);
    run("R5",  300, 70, 0, 1, 20,  0, 30, 0);
    run("R6",  300, 70, 2, 2, 20, 10, 60, 0);
    run("R7",  300, 70, 0, 1, 20, 10, 30, 0);
    run("R8",  300, 70, 3, 3, 20, 10, 60, 0);
    run("R10", 300, 60, 0, 3,  0, 40, 30, 0);
    run("R11", 400, 90, 0, 3, 60, 60, 60, 0);
    run("R12", 400, 15, 0, 3, 30, 30, 60, 0);
    run("R1",  300, 60, 0, 3, 50,  0, 30, 0);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule